// File: doc/BRIEF.md
# PCIe Function-Reset Outbound Request Gate

This block sits between an on-chip master and a PCIe core, on the path that carries outbound requests. It holds a stop-request bit for each physical function. Hardware sets a function's bit when that function enters function-level reset, and only a software write can clear it. While the bit is set, every posted or non-posted request from that function, or from any of its child virtual functions, is removed before it reaches the core. Completions travel the same path and are never blocked.

The two kinds of dropped request are handled differently. A posted request is accepted and thrown away with no response. A non-posted request is answered in the same cycle by a locally built completion that carries an unsupported-request status, so the requester never waits on a timeout. Each drop also sets a sticky bus-master-disabled flag for its function, and an interrupt output stays high while any of these flags is set.

Software sees two 64-bit views selected by `csr_sel_i`: the stop bits and the error flags. Both are write-one-to-clear. The active-low asynchronous reset acts as the MAC reset and clears everything. A synchronous soft reset clears the error flags and leaves the stop bits unchanged.

Top module: `flr_req_gate`

## Requirements
- R1: Register view: with `csr_sel_i`=0 the 64-bit `csr_rdata_o` shows the stop bits, with `csr_sel_i`=1 it shows the error flags; function n sits at bit n (bits 0 to NUM_PF-1), and all higher bits read zero.
- R2: A pulse on `flr_enter_i[n]` sets stop bit n on the next clock edge, and the bit stays set until software clears it.
- R3: A write with `csr_sel_i`=0 clears every stop bit whose `csr_wdata_i` bit is 1 and leaves the others unchanged; a hardware set in the same cycle wins over the clear.
- R4: Request kind encoding: 0 = posted, 1 = non-posted, 2 = completion. A posted or non-posted request whose function's stop bit is set is never presented to the core (`core_valid_o` low), whatever its `req_vf_i` value; a dropped posted request is accepted at once (`req_ready_o` high).
- R5: A dropped non-posted request raises `ecpl_valid_o` in the same cycle, with `ecpl_tag_o` and `ecpl_rid_o` equal to the request's tag and requester ID and `ecpl_status_o` = 3'b001 (unsupported request); `req_ready_o` then follows `ecpl_ready_i`.
- R6: Completions, and requests from functions whose stop bit is clear, pass to the core unchanged in the same cycle, with `req_ready_o` following `core_ready_i` and no error completion.
- R7: Each accepted drop sets the error flag of its function on the next edge. The flag stays set until a write with `csr_sel_i`=1 and a 1 in that bit position clears it. A drop in the same cycle wins over that clear. `irq_o` is the OR of all error flags.
- R8: `rst_ni` low clears the stop bits and the error flags; `soft_rst_i` high clears the error flags on the next edge and leaves the stop bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low async MAC reset |
| soft_rst_i | input | 1 | Synchronous soft reset, clears error flags only |
| flr_enter_i | input | NUM_PF | Per-function reset entry pulse from hardware |
| csr_wr_i | input | 1 | Register write strobe |
| csr_sel_i | input | 1 | 0 = stop bits, 1 = error flags |
| csr_wdata_i | input | 64 | Write data, 1 clears the bit |
| csr_rdata_o | output | 64 | Read data of the selected view |
| req_valid_i | input | 1 | Outbound request valid |
| req_ready_o | output | 1 | Outbound request accepted |
| req_kind_i | input | 2 | 0 posted, 1 non-posted, 2 completion |
| req_pf_i | input | PF_W | Physical function number |
| req_vf_i | input | VF_W | Child virtual function, 0 = the function itself |
| req_tag_i | input | TAG_W | Transaction tag |
| req_rid_i | input | RID_W | Requester ID |
| req_data_i | input | DATA_W | Payload |
| core_valid_o | output | 1 | Request valid toward the core |
| core_ready_i | input | 1 | Core accepts the request |
| core_kind_o | output | 2 | Forwarded kind |
| core_pf_o | output | PF_W | Forwarded function |
| core_vf_o | output | VF_W | Forwarded virtual function |
| core_tag_o | output | TAG_W | Forwarded tag |
| core_rid_o | output | RID_W | Forwarded requester ID |
| core_data_o | output | DATA_W | Forwarded payload |
| ecpl_valid_o | output | 1 | Local error completion valid |
| ecpl_ready_i | input | 1 | Requester accepts the error completion |
| ecpl_tag_o | output | TAG_W | Echoed tag |
| ecpl_rid_o | output | RID_W | Echoed requester ID |
| ecpl_status_o | output | 3 | Completion status, 3'b001 |
| irq_o | output | 1 | Error interrupt |

## Verification
The bench builds the block with its defaults: three functions, a two-bit function field, and 8-bit tags. Because the function field is two bits wide, the unused encoding 3 can be driven. With three functions, one stopped function can sit between two running ones, so a single table pass shows that gating stays on the right function. The small tag and requester-ID widths let the error-completion echo be compared field by field against hand-picked values.

// File: rtl/flr_gate_pkg.sv
package flr_gate_pkg;
  localparam int unsigned KIND_W = 2;
  localparam int unsigned STS_W  = 3;
  localparam int unsigned REG_W  = 64;
  localparam logic [KIND_W-1:0] KIND_P   = 2'd0;
  localparam logic [KIND_W-1:0] KIND_NP  = 2'd1;
  localparam logic [KIND_W-1:0] KIND_CPL = 2'd2;
  localparam logic [STS_W-1:0]  STS_UR   = 3'b001;
endpackage

// File: rtl/flr_bit_bank.sv
module flr_bit_bank #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sclr_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] w1c_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q_q;

  // per bit: sync clear > set > w1c
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q_q[i] <= 1'b0;
      else if (sclr_i)    q_q[i] <= 1'b0;
      else if (set_i[i])  q_q[i] <= 1'b1;
      else if (w1c_i[i])  q_q[i] <= 1'b0;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/flr_req_filter.sv
module flr_req_filter
  import flr_gate_pkg::*;
#(
  parameter int unsigned NUM_PF = 3,
  parameter int unsigned PF_W   = 2
) (
  input  logic              req_valid_i,
  input  logic [KIND_W-1:0] req_kind_i,
  input  logic [PF_W-1:0]   req_pf_i,
  input  logic [NUM_PF-1:0] stop_i,
  input  logic              core_ready_i,
  input  logic              ecpl_ready_i,
  output logic              core_valid_o,
  output logic              ecpl_valid_o,
  output logic              req_ready_o,
  output logic [NUM_PF-1:0] drop_set_o
);
  logic [NUM_PF-1:0] pf_hot;
  logic              is_req, stopped, drop, drop_np, fire;

  // out-of-range function numbers decode to no bit and are never gated
  assign pf_hot  = NUM_PF'(1) << req_pf_i;
  assign is_req  = (req_kind_i == KIND_P) || (req_kind_i == KIND_NP);
  assign stopped = |(stop_i & pf_hot);
  assign drop    = is_req && stopped;
  assign drop_np = drop && (req_kind_i == KIND_NP);

  always_comb begin
    if (!drop)        req_ready_o = core_ready_i;
    else if (drop_np) req_ready_o = ecpl_ready_i;
    else              req_ready_o = 1'b1;
  end

  assign core_valid_o = req_valid_i && !drop;
  assign ecpl_valid_o = req_valid_i && drop_np;
  assign fire         = req_valid_i && drop && req_ready_o;
  assign drop_set_o   = fire ? pf_hot : '0;
endmodule

// File: rtl/flr_req_gate.sv
module flr_req_gate
  import flr_gate_pkg::*;
#(
  parameter int unsigned NUM_PF = 3,
  parameter int unsigned PF_W   = (NUM_PF > 1) ? $clog2(NUM_PF) : 1,
  parameter int unsigned VF_W   = 6,
  parameter int unsigned TAG_W  = 8,
  parameter int unsigned RID_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic [NUM_PF-1:0] flr_enter_i,
  input  logic              csr_wr_i,
  input  logic              csr_sel_i,
  input  logic [63:0]       csr_wdata_i,
  output logic [63:0]       csr_rdata_o,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_kind_i,
  input  logic [PF_W-1:0]   req_pf_i,
  input  logic [VF_W-1:0]   req_vf_i,
  input  logic [TAG_W-1:0]  req_tag_i,
  input  logic [RID_W-1:0]  req_rid_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              core_valid_o,
  input  logic              core_ready_i,
  output logic [1:0]        core_kind_o,
  output logic [PF_W-1:0]   core_pf_o,
  output logic [VF_W-1:0]   core_vf_o,
  output logic [TAG_W-1:0]  core_tag_o,
  output logic [RID_W-1:0]  core_rid_o,
  output logic [DATA_W-1:0] core_data_o,
  output logic              ecpl_valid_o,
  input  logic              ecpl_ready_i,
  output logic [TAG_W-1:0]  ecpl_tag_o,
  output logic [RID_W-1:0]  ecpl_rid_o,
  output logic [2:0]        ecpl_status_o,
  output logic              irq_o
);
  logic [NUM_PF-1:0] stop_q, err_q, drop_set, stop_w1c, err_w1c;
  logic              unused_wdata;

  assign stop_w1c     = (csr_wr_i && !csr_sel_i) ? csr_wdata_i[NUM_PF-1:0] : '0;
  assign err_w1c      = (csr_wr_i &&  csr_sel_i) ? csr_wdata_i[NUM_PF-1:0] : '0;
  assign unused_wdata = ^csr_wdata_i[REG_W-1:NUM_PF];

  flr_bit_bank #(.N(NUM_PF)) u_stop (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclr_i (1'b0),
    .set_i  (flr_enter_i),
    .w1c_i  (stop_w1c),
    .q_o    (stop_q)
  );

  flr_bit_bank #(.N(NUM_PF)) u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclr_i (soft_rst_i),
    .set_i  (drop_set),
    .w1c_i  (err_w1c),
    .q_o    (err_q)
  );

  flr_req_filter #(.NUM_PF(NUM_PF), .PF_W(PF_W)) u_filter (
    .req_valid_i  (req_valid_i),
    .req_kind_i   (req_kind_i),
    .req_pf_i     (req_pf_i),
    .stop_i       (stop_q),
    .core_ready_i (core_ready_i),
    .ecpl_ready_i (ecpl_ready_i),
    .core_valid_o (core_valid_o),
    .ecpl_valid_o (ecpl_valid_o),
    .req_ready_o  (req_ready_o),
    .drop_set_o   (drop_set)
  );

  assign csr_rdata_o   = REG_W'(csr_sel_i ? err_q : stop_q);
  assign irq_o         = |err_q;

  assign core_kind_o   = req_kind_i;
  assign core_pf_o     = req_pf_i;
  assign core_vf_o     = req_vf_i;
  assign core_tag_o    = req_tag_i;
  assign core_rid_o    = req_rid_i;
  assign core_data_o   = req_data_i;

  assign ecpl_tag_o    = req_tag_i;
  assign ecpl_rid_o    = req_rid_i;
  assign ecpl_status_o = STS_UR;
endmodule

// File: rtl/flr_req_gate_chk.sv
module flr_req_gate_chk
  import flr_gate_pkg::*;
#(
  parameter int unsigned NUM_PF = 3,
  parameter int unsigned PF_W   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              soft_rst_i,
  input logic [NUM_PF-1:0] flr_enter_i,
  input logic [63:0]       csr_rdata_o,
  input logic              req_valid_i,
  input logic [1:0]        req_kind_i,
  input logic [PF_W-1:0]   req_pf_i,
  input logic              core_valid_o,
  input logic              ecpl_valid_o,
  input logic              ecpl_ready_i,
  input logic              irq_o,
  input logic [NUM_PF-1:0] stop_q,
  input logic [NUM_PF-1:0] err_q
);
  // R1
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_rdata_o[63:NUM_PF] == '0);

  // R2
  flr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|flr_enter_i) |=> ((stop_q & $past(flr_enter_i)) == $past(flr_enter_i)));

  // R4
  stopped_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (req_kind_i == KIND_P || req_kind_i == KIND_NP) &&
     |(stop_q & (NUM_PF'(1) << req_pf_i))) |-> !core_valid_o);

  // R5
  ecpl_np_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecpl_valid_o |-> (req_kind_i == KIND_NP && !core_valid_o));

  // R6
  cpl_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_kind_i == KIND_CPL) |-> (core_valid_o && !ecpl_valid_o));

  // R7
  drop_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ecpl_valid_o && ecpl_ready_i && !soft_rst_i) |=> irq_o);

  // R8
  soft_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (err_q == '0 && (stop_q & $past(stop_q)) == $past(stop_q)));
endmodule

bind flr_req_gate flr_req_gate_chk #(.NUM_PF(NUM_PF), .PF_W(PF_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .soft_rst_i   (soft_rst_i),
  .flr_enter_i  (flr_enter_i),
  .csr_rdata_o  (csr_rdata_o),
  .req_valid_i  (req_valid_i),
  .req_kind_i   (req_kind_i),
  .req_pf_i     (req_pf_i),
  .core_valid_o (core_valid_o),
  .ecpl_valid_o (ecpl_valid_o),
  .ecpl_ready_i (ecpl_ready_i),
  .irq_o        (irq_o),
  .stop_q       (stop_q),
  .err_q        (err_q)
);

// File: tb/flr_req_gate_tb.sv
module flr_req_gate_tb;
  localparam int NUM_PF = 3;
  localparam int PF_W   = 2;
  localparam int VF_W   = 6;
  localparam int TAG_W  = 8;
  localparam int RID_W  = 16;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic soft_rst_i = 1'b0;
  logic [NUM_PF-1:0] flr_enter_i = '0;
  logic csr_wr_i = 1'b0, csr_sel_i = 1'b0;
  logic [63:0] csr_wdata_i = '0, csr_rdata_o;
  logic req_valid_i = 1'b0, req_ready_o;
  logic [1:0] req_kind_i = '0;
  logic [PF_W-1:0] req_pf_i = '0;
  logic [VF_W-1:0] req_vf_i = '0;
  logic [TAG_W-1:0] req_tag_i = '0;
  logic [RID_W-1:0] req_rid_i = '0;
  logic [DATA_W-1:0] req_data_i = '0;
  logic core_valid_o, core_ready_i = 1'b0;
  logic [1:0] core_kind_o;
  logic [PF_W-1:0] core_pf_o;
  logic [VF_W-1:0] core_vf_o;
  logic [TAG_W-1:0] core_tag_o;
  logic [RID_W-1:0] core_rid_o;
  logic [DATA_W-1:0] core_data_o;
  logic ecpl_valid_o, ecpl_ready_i = 1'b0;
  logic [TAG_W-1:0] ecpl_tag_o;
  logic [RID_W-1:0] ecpl_rid_o;
  logic [2:0] ecpl_status_o;
  logic irq_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  flr_req_gate u_dut (.*, .clk_i(clk));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic csr_write(logic sel, logic [63:0] d);
    csr_wr_i = 1'b1; csr_sel_i = sel; csr_wdata_i = d;
    tick();
    csr_wr_i = 1'b0; csr_wdata_i = '0;
  endtask

  task automatic read_view(logic sel, string req, logic [63:0] exp);
    csr_sel_i = sel;
    #0.5;
    chk(req, csr_rdata_o, exp);
  endtask

  // {kind[8:7], pf[6:5], core_ready[4], ecpl_ready[3], exp core_valid[2], exp ecpl_valid[1], exp req_ready[0]}
  // function 1 stopped, 0 and 2 running
  localparam logic [8:0] VEC [8] = '{
    {2'd0, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    {2'd1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    {2'd1, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    {2'd1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    {2'd2, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    {2'd2, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {2'd1, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    read_view(1'b0, "R8 reset stop", 64'h0);
    read_view(1'b1, "R8 reset err", 64'h0);
    chk("R8 reset irq", {63'h0, irq_o}, 64'h0);
    rst_ni = 1'b1;
    tick();

    // R2 set function 1
    flr_enter_i = 3'b010; tick(); flr_enter_i = '0;
    tick();
    read_view(1'b0, "R2 stop set and held", 64'h2);

    // R4 R5 R6 vector walk
    for (int i = 0; i < 8; i++) begin
      req_valid_i  = 1'b1;
      req_kind_i   = VEC[i][8:7];
      req_pf_i     = VEC[i][6:5];
      req_vf_i     = VF_W'(i);
      req_tag_i    = TAG_W'(8'h40 + i);
      req_rid_i    = RID_W'(16'h1200 + i);
      req_data_i   = DATA_W'(32'hA000_0000 + i);
      core_ready_i = VEC[i][4];
      ecpl_ready_i = VEC[i][3];
      #0.5;
      chk($sformatf("R4 core_valid vec%0d", i), {63'h0, core_valid_o}, {63'h0, VEC[i][2]});
      chk($sformatf("R5 ecpl_valid vec%0d", i), {63'h0, ecpl_valid_o}, {63'h0, VEC[i][1]});
      chk($sformatf("R6 req_ready vec%0d", i), {63'h0, req_ready_o}, {63'h0, VEC[i][0]});
      tick();
    end
    req_valid_i = 1'b0;
    // two accepted drops of function 1: error flag 1 only
    read_view(1'b1, "R7 err after drops", 64'h2);
    chk("R7 irq", {63'h0, irq_o}, 64'h1);

    // R5 echo of tag and requester id, VF of stopped PF
    req_valid_i = 1'b1; req_kind_i = 2'd1; req_pf_i = 2'd1; req_vf_i = 6'd9;
    req_tag_i = 8'hC3; req_rid_i = 16'hBEEF; ecpl_ready_i = 1'b0; core_ready_i = 1'b1;
    #0.5;
    chk("R5 ecpl tag", {56'h0, ecpl_tag_o}, 64'hC3);
    chk("R5 ecpl rid", {48'h0, ecpl_rid_o}, 64'hBEEF);
    chk("R5 ecpl status", {61'h0, ecpl_status_o}, 64'h1);
    chk("R4 vf of stopped pf", {63'h0, core_valid_o}, 64'h0);
    // R6 unused function number 3 passes with data intact
    req_pf_i = 2'd3; req_kind_i = 2'd0; req_data_i = 32'h5A5A_1234;
    #0.5;
    chk("R6 pf3 passes", {63'h0, core_valid_o}, 64'h1);
    chk("R6 data intact", {32'h0, core_data_o}, 64'h5A5A_1234);
    req_valid_i = 1'b0;
    @(negedge clk);

    // R3 w1c, reserved bits ignored
    csr_write(1'b0, 64'hFFFF_FFFF_FFFF_FFFD);
    read_view(1'b0, "R3 w1c other bits", 64'h2);
    csr_write(1'b0, 64'h2);
    read_view(1'b0, "R3 w1c clears", 64'h0);
    // R3 set wins over clear
    flr_enter_i = 3'b001;
    csr_write(1'b0, 64'h1);
    flr_enter_i = '0;
    read_view(1'b0, "R3 set beats clear", 64'h1);
    read_view(1'b0, "R1 reserved zero", 64'h1);

    // R7 drop wins over clear in same cycle
    req_valid_i = 1'b1; req_kind_i = 2'd0; req_pf_i = 2'd0;
    csr_write(1'b1, 64'h1);
    req_valid_i = 1'b0;
    read_view(1'b1, "R7 drop beats clear", 64'h3);
    csr_write(1'b1, 64'h2);
    read_view(1'b1, "R7 w1c err", 64'h1);

    // R8 soft reset keeps stop, clears err
    soft_rst_i = 1'b1; tick(); soft_rst_i = 1'b0;
    read_view(1'b1, "R8 soft clears err", 64'h0);
    chk("R7 irq low", {63'h0, irq_o}, 64'h0);
    read_view(1'b0, "R8 soft keeps stop", 64'h1);

    // R8 MAC reset clears stop
    rst_ni = 1'b0; #0.5;
    read_view(1'b0, "R8 mac reset stop", 64'h0);
    @(negedge clk); rst_ni = 1'b1;
    tick();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule